// File: doc/BRIEF.md
# Line interface loopback controller

This block sets up the data paths around a T1/E1 line interface using a group of discrete control inputs. While an active-low select input is held low, it captures the following settings: a local loopback request, a remote loopback request, a continuous-marks request, a line length code and a decoder choice. Once the select input goes high, the captured settings are kept. A second register stage turns the captured settings into an operating mode one clock later. The output multiplexers always switch from a registered mode, so they do not glitch.

The steering logic routes three sources: the transmit stream, the stream recovered from the line, and an all-ones source. These go to the line-driver outputs and to the receive outputs. In normal operation the transmit stream feeds the driver and the line stream feeds the receive outputs. In local loopback the transmit stream is also returned to the receive outputs, the line inputs are not used, and a bypass select is raised for an external jitter attenuator. In remote loopback the driver is fed from the output of the external jitter attenuator, which carries the recovered stream. An all-ones request replaces the transmitted data in normal operation and in local loopback. Remote loopback ignores it.

If both loopback inputs stay high together for a set number of clock cycles, the block treats this as a reset command and not as a mode. It emits a one-cycle reset pulse and returns the captured state to normal operation.

Top module: `lpbk_ctrl`

## Requirements
- R1: Settings on the control inputs are sampled at each clock edge where `sel_n` is low. They reach the outputs (`len_o`, `zs_en_o`, `ja_bypass_o`, routing) after the following edge, so the latency is two edges. While `sel_n` stays high the outputs hold their values.
- R2: In normal mode, `drv_clk_o`/`drv_data_o` follow `tx_clk_i`/`tx_data_i`, and `rcv_clk_o`/`rcv_data_o` follow `rx_clk_i`/`rx_data_i`.
- R3: In local loopback (local captured 1, remote captured 0), `rcv_clk_o`/`rcv_data_o` follow `tx_clk_i`/`tx_data_i` and the line inputs `rx_clk_i`/`rx_data_i` have no effect. The driver is still fed from the transmit stream.
- R4: In local loopback with the all-ones request captured as 1, every bit of `drv_data_o` is 1 and `drv_clk_o` follows `tx_clk_i`. The receive outputs still carry `tx_data_i`.
- R5: `ja_bypass_o` is 1 in local loopback and 0 in every other mode.
- R6: In remote loopback (remote 1, local 0), `drv_clk_o`/`drv_data_o` follow `ja_clk_i`/`ja_data_i` and the receive outputs follow the line inputs. An all-ones request has no effect.
- R7: In normal mode with the all-ones request captured as 1, every bit of `drv_data_o` is 1.
- R8: A captured `dec_sel_i` of 0 gives `zs_en_o`=1, which selects zero-substitution decoding. A captured 1 gives `zs_en_o`=0, which selects plain AMI decoding.
- R9: When `local_lb_i` and `remote_lb_i` are both sampled high on RST_CYC consecutive edges, `dev_rst_o` is 1 for exactly the one cycle after the RST_CYC-th edge. RST_CYC-1 edges produce no pulse, and continued overlap does not repeat the pulse.
- R10: The edge that raises `dev_rst_o` clears the captured state and the mode to normal: no all-ones, `len_o`=0, `zs_en_o`=0. The asynchronous reset gives the same state.
- R11: If both loopback requests are captured high, the routing is that of normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel_n | input | 1 | Active-low capture enable for the control inputs |
| local_lb_i | input | 1 | Local loopback request |
| remote_lb_i | input | 1 | Remote loopback request |
| all_ones_i | input | 1 | Continuous-marks request |
| len_i | input | LEN_W | Line length code |
| dec_sel_i | input | 1 | Decoder choice (0 zero-substitution, 1 AMI) |
| tx_clk_i | input | 1 | Transmit clock |
| tx_data_i | input | DATA_W | Transmit data |
| rx_clk_i | input | 1 | Clock recovered from the line |
| rx_data_i | input | DATA_W | Data recovered from the line |
| ja_clk_i | input | 1 | Clock from the external jitter attenuator |
| ja_data_i | input | DATA_W | Data from the external jitter attenuator |
| drv_clk_o | output | 1 | Clock to the line driver |
| drv_data_o | output | DATA_W | Data to the line driver |
| rcv_clk_o | output | 1 | Receive clock output |
| rcv_data_o | output | DATA_W | Receive data output |
| ja_bypass_o | output | 1 | Jitter attenuator bypass select |
| zs_en_o | output | 1 | Zero-substitution decoder enable |
| len_o | output | LEN_W | Registered line length code |
| dev_rst_o | output | 1 | One-cycle reset pulse |

## Verification
The assertions assume that the select and loopback inputs are synchronous to `clk` and change only between edges. They also assume that any overlap of the two loopback requests that is meant as a mode lasts for fewer than RST_CYC edges. The stimulus changes all inputs shortly after a rising edge. It raises both loopback inputs only for one capture cycle, or on purpose during the reset-request tests. It returns them low as soon as a setting has been captured, so routing checks never overlap with an unintended reset.

// File: rtl/lbc_pkg.sv
package lbc_pkg;
  parameter int LEN_W = 3;

  typedef enum logic [1:0] {
    LB_NORM   = 2'd0,
    LB_LOCAL  = 2'd1,
    LB_REMOTE = 2'd2
  } lb_mode_e;

  typedef struct packed {
    logic             loc;
    logic             rem;
    logic             ones;
    logic             zs_en;
    logic [LEN_W-1:0] len;
  } lb_cap_t;
endpackage

// File: rtl/lbc_capture.sv
module lbc_capture
  import lbc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_n,
  input  logic             clr_i,
  input  logic             loc_i,
  input  logic             rem_i,
  input  logic             ones_i,
  input  logic             dec_sel_i,
  input  logic [LEN_W-1:0] len_i,
  output lb_mode_e         mode_o,
  output logic             ones_o,
  output logic             zs_en_o,
  output logic [LEN_W-1:0] len_o
);
  lb_cap_t  cap_q, cap_d;
  lb_mode_e mode_q, mode_d;
  logic     ones_q, ones_d;
  logic     zs_q, zs_d;
  logic [LEN_W-1:0] len_q, len_d;

  // capture stage next state
  always_comb begin
    cap_d = cap_q;
    if (clr_i) begin
      cap_d = '0;
    end else if (!sel_n) begin
      cap_d.loc   = loc_i;
      cap_d.rem   = rem_i;
      cap_d.ones  = ones_i;
      cap_d.zs_en = ~dec_sel_i;
      cap_d.len   = len_i;
    end
  end

  // mode stage next state, one edge behind capture
  always_comb begin
    mode_d = LB_NORM;
    ones_d = cap_q.ones;
    zs_d   = cap_q.zs_en;
    len_d  = cap_q.len;
    if (cap_q.loc && !cap_q.rem)      mode_d = LB_LOCAL;
    else if (cap_q.rem && !cap_q.loc) mode_d = LB_REMOTE;
    if (clr_i) begin
      mode_d = LB_NORM;
      ones_d = 1'b0;
      zs_d   = 1'b0;
      len_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q  <= '0;
      mode_q <= LB_NORM;
      ones_q <= 1'b0;
      zs_q   <= 1'b0;
      len_q  <= '0;
    end else begin
      cap_q  <= cap_d;
      mode_q <= mode_d;
      ones_q <= ones_d;
      zs_q   <= zs_d;
      len_q  <= len_d;
    end
  end

  assign mode_o  = mode_q;
  assign ones_o  = ones_q;
  assign zs_en_o = zs_q;
  assign len_o   = len_q;
endmodule

// File: rtl/lbc_rst_det.sv
module lbc_rst_det #(
  parameter int RST_CYC = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic loc_i,
  input  logic rem_i,
  output logic fire_o,
  output logic pulse_o
);
  localparam int CNT_W = $clog2(RST_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RST_CYC - 1);
  localparam logic [CNT_W-1:0] SAT  = CNT_W'(RST_CYC);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pulse_q;
  logic             both;

  assign both   = loc_i & rem_i;
  assign fire_o = both && (cnt_q == LAST);

  always_comb begin
    cnt_d = '0;
    if (both) cnt_d = (cnt_q == SAT) ? cnt_q : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pulse_q <= fire_o;
    end
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/lbc_route.sv
module lbc_route
  import lbc_pkg::*;
#(
  parameter int DATA_W = 2
) (
  input  lb_mode_e          mode_i,
  input  logic              ones_i,
  input  logic              tx_clk_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              rx_clk_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              ja_clk_i,
  input  logic [DATA_W-1:0] ja_data_i,
  output logic              drv_clk_o,
  output logic [DATA_W-1:0] drv_data_o,
  output logic              rcv_clk_o,
  output logic [DATA_W-1:0] rcv_data_o,
  output logic              ja_bypass_o
);
  logic [DATA_W-1:0] tx_sel;

  assign tx_sel = ones_i ? {DATA_W{1'b1}} : tx_data_i;

  always_comb begin
    drv_clk_o   = tx_clk_i;
    drv_data_o  = tx_sel;
    rcv_clk_o   = rx_clk_i;
    rcv_data_o  = rx_data_i;
    ja_bypass_o = 1'b0;
    unique case (mode_i)
      LB_LOCAL: begin
        rcv_clk_o   = tx_clk_i;
        rcv_data_o  = tx_data_i;
        ja_bypass_o = 1'b1;
      end
      LB_REMOTE: begin
        drv_clk_o  = ja_clk_i;
        drv_data_o = ja_data_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/lpbk_ctrl.sv
module lpbk_ctrl
  import lbc_pkg::*;
#(
  parameter int DATA_W  = 2,
  parameter int RST_CYC = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              local_lb_i,
  input  logic              remote_lb_i,
  input  logic              all_ones_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              dec_sel_i,
  input  logic              tx_clk_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              rx_clk_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              ja_clk_i,
  input  logic [DATA_W-1:0] ja_data_i,
  output logic              drv_clk_o,
  output logic [DATA_W-1:0] drv_data_o,
  output logic              rcv_clk_o,
  output logic [DATA_W-1:0] rcv_data_o,
  output logic              ja_bypass_o,
  output logic              zs_en_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              dev_rst_o
);
  logic [1:0] rsync_q;
  logic       rst_int_n;
  logic       fire;
  lb_mode_e   mode;
  logic       ones;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  lbc_rst_det #(.RST_CYC(RST_CYC)) u_det (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .loc_i   (local_lb_i),
    .rem_i   (remote_lb_i),
    .fire_o  (fire),
    .pulse_o (dev_rst_o)
  );

  lbc_capture u_cap (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .sel_n     (sel_n),
    .clr_i     (fire),
    .loc_i     (local_lb_i),
    .rem_i     (remote_lb_i),
    .ones_i    (all_ones_i),
    .dec_sel_i (dec_sel_i),
    .len_i     (len_i),
    .mode_o    (mode),
    .ones_o    (ones),
    .zs_en_o   (zs_en_o),
    .len_o     (len_o)
  );

  lbc_route #(.DATA_W(DATA_W)) u_route (
    .mode_i      (mode),
    .ones_i      (ones),
    .tx_clk_i    (tx_clk_i),
    .tx_data_i   (tx_data_i),
    .rx_clk_i    (rx_clk_i),
    .rx_data_i   (rx_data_i),
    .ja_clk_i    (ja_clk_i),
    .ja_data_i   (ja_data_i),
    .drv_clk_o   (drv_clk_o),
    .drv_data_o  (drv_data_o),
    .rcv_clk_o   (rcv_clk_o),
    .rcv_data_o  (rcv_data_o),
    .ja_bypass_o (ja_bypass_o)
  );
endmodule

// File: rtl/lbc_chk.sv
module lbc_chk
  import lbc_pkg::*;
#(
  parameter int DATA_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_n,
  input logic              local_lb_i,
  input logic              remote_lb_i,
  input logic [DATA_W-1:0] tx_data_i,
  input logic [DATA_W-1:0] rcv_data_o,
  input logic              ja_bypass_o,
  input logic              zs_en_o,
  input logic [LEN_W-1:0]  len_o,
  input logic              dev_rst_o
);
  // R1
  hold_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dev_rst_o && !$past(dev_rst_o) && $past(sel_n, 2)) |-> $stable(len_o));

  // R9
  one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rst_o |=> !dev_rst_o);

  // R9
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rst_o |-> $past(local_lb_i && remote_lb_i));

  // R10
  clear_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rst_o |-> (!ja_bypass_o && !zs_en_o && len_o == '0));

  // R3
  local_rcv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ja_bypass_o |-> (rcv_data_o == tx_data_i));
endmodule

bind lpbk_ctrl lbc_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sel_n       (sel_n),
  .local_lb_i  (local_lb_i),
  .remote_lb_i (remote_lb_i),
  .tx_data_i   (tx_data_i),
  .rcv_data_o  (rcv_data_o),
  .ja_bypass_o (ja_bypass_o),
  .zs_en_o     (zs_en_o),
  .len_o       (len_o),
  .dev_rst_o   (dev_rst_o)
);

// File: tb/sim_lpbk_ctrl.sv
module sim_lpbk_ctrl;
  localparam int DW = 2;
  localparam int LW = 3;
  localparam int RC = 10;

  logic clk, rst_n, sel_n, loc, rem, ones, dec;
  logic [LW-1:0] len;
  logic txc, rxc, jac;
  logic [DW-1:0] txd, rxd, jad;
  logic drv_c, rcv_c, byp, zs, drst;
  logic [DW-1:0] drv_d, rcv_d;
  logic [LW-1:0] len_out;

  lpbk_ctrl #(.DATA_W(DW), .RST_CYC(RC)) u0 (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .local_lb_i(loc),
    .remote_lb_i(rem), .all_ones_i(ones), .len_i(len), .dec_sel_i(dec),
    .tx_clk_i(txc), .tx_data_i(txd), .rx_clk_i(rxc), .rx_data_i(rxd),
    .ja_clk_i(jac), .ja_data_i(jad), .drv_clk_o(drv_c), .drv_data_o(drv_d),
    .rcv_clk_o(rcv_c), .rcv_data_o(rcv_d), .ja_bypass_o(byp),
    .zs_en_o(zs), .len_o(len_out), .dev_rst_o(drst)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct {
    string         tag;
    logic [12:0]   vec;
  } item_t;
  item_t sbq[$];

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // expected configuration
  logic m_loc, m_rem, m_ones, m_zs;
  logic [LW-1:0] m_len;

  function automatic logic [12:0] model(logic rst_exp);
    logic dc, rc, bp;
    logic [DW-1:0] dd, rd;
    dc = txc; dd = m_ones ? '1 : txd; rc = rxc; rd = rxd; bp = 1'b0;
    if (m_loc && !m_rem) begin rc = txc; rd = txd; bp = 1'b1; end
    else if (m_rem && !m_loc) begin dc = jac; dd = jad; end
    return {dc, dd, rc, rd, bp, m_zs, m_len, rst_exp};
  endfunction

  task automatic push(string tag, logic rst_exp = 1'b0);
    item_t it;
    it.tag = tag;
    it.vec = model(rst_exp);
    sbq.push_back(it);
  endtask

  // monitor: compares between edges
  always @(negedge clk) begin
    while (sbq.size() > 0) begin
      item_t it;
      logic [12:0] act;
      it = sbq.pop_front();
      act = {drv_c, drv_d, rcv_c, rcv_d, byp, zs, len_out, drst};
      checks++;
      if (act !== it.vec) begin
        errors++;
        $display("FAIL %s: actual %b expected %b", it.tag, act, it.vec);
      end
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic stim(string tag, logic tc, logic [DW-1:0] td,
                      logic rc, logic [DW-1:0] rd, logic jc, logic [DW-1:0] jd);
    step();
    txc = tc; txd = td; rxc = rc; rxd = rd; jac = jc; jad = jd;
    #1 push(tag);
  endtask

  task automatic cfg(logic l, logic r, logic o, logic [LW-1:0] ln, logic d);
    step();
    sel_n = 1'b0; loc = l; rem = r; ones = o; len = ln; dec = d;
    step();
    sel_n = 1'b1; loc = 1'b0; rem = 1'b0;
    step();
    m_loc = l; m_rem = r; m_ones = o; m_len = ln; m_zs = ~d;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sel_n = 1'b1; loc = 0; rem = 0; ones = 0; dec = 0; len = '0;
    txc = 0; txd = '0; rxc = 0; rxd = '0; jac = 0; jad = '0;
    m_loc = 0; m_rem = 0; m_ones = 0; m_zs = 0; m_len = '0;
    repeat (4) step();
    rst_n = 1'b1;
    repeat (4) step();

    // R10 reset state, R2 normal routing
    stim("R10 reset state", 1, 2'b01, 0, 2'b10, 1, 2'b11);
    stim("R2 normal a", 0, 2'b10, 1, 2'b01, 0, 2'b00);
    cfg(0, 0, 0, 3'd3, 0);
    stim("R2 normal b / R8 zs", 1, 2'b11, 0, 2'b00, 1, 2'b01);
    cfg(0, 0, 1, 3'd3, 1);
    stim("R7 normal ones / R8 ami", 1, 2'b00, 1, 2'b10, 0, 2'b01);

    // R3 R4 R5 local loopback
    cfg(1, 0, 0, 3'd1, 0);
    stim("R3 local a", 1, 2'b01, 0, 2'b11, 1, 2'b10);
    stim("R3 local rx ignored", 1, 2'b01, 1, 2'b00, 0, 2'b01);
    stim("R5 local bypass", 0, 2'b10, 1, 2'b01, 1, 2'b11);
    cfg(1, 0, 1, 3'd1, 0);
    stim("R4 local ones", 1, 2'b00, 0, 2'b01, 1, 2'b10);
    stim("R4 local ones b", 0, 2'b10, 1, 2'b11, 0, 2'b00);

    // R6 remote, ones ignored
    cfg(0, 1, 1, 3'd4, 1);
    stim("R6 remote ones ignored", 1, 2'b00, 0, 2'b10, 1, 2'b01);
    stim("R6 remote b", 0, 2'b11, 1, 2'b01, 0, 2'b10);

    // R11 both captured
    cfg(1, 1, 0, 3'd2, 0);
    stim("R11 both normal", 1, 2'b01, 0, 2'b10, 1, 2'b00);

    // R1 latency and hold
    step();
    sel_n = 1'b0; len = 3'd5; dec = 1'b1; ones = 1'b0;
    #1 push("R1 before capture");
    step();
    sel_n = 1'b1; len = 3'd7; dec = 1'b0;
    #1 push("R1 captured not applied");
    step();
    m_len = 3'd5; m_zs = 1'b0; m_loc = 0; m_rem = 0; m_ones = 0;
    #1 push("R1 applied");
    step(); len = 3'd6; dec = 1'b1; ones = 1'b1; loc = 1'b1;
    step(); loc = 1'b0;
    step();
    #1 push("R1 hold");

    // R9 one cycle short
    cfg(1, 0, 1, 3'd6, 1);
    step(); loc = 1'b1; rem = 1'b1;
    for (int k = 1; k < RC; k++) begin
      step();
      if (k == RC - 1) begin loc = 1'b0; rem = 1'b0; end
      #1 push("R9 short no pulse");
    end
    step(); #1 push("R9 short after");
    step(); #1 push("R9 short after b");

    // R9 exact threshold, R10 clear
    step(); loc = 1'b1; rem = 1'b1;
    for (int k = 1; k < RC; k++) begin
      step(); #1 push("R9 counting");
    end
    step();
    m_loc = 0; m_rem = 0; m_ones = 0; m_len = '0; m_zs = 0;
    #1 push("R9 pulse / R10 cleared", 1'b1);
    step(); #1 push("R9 no repeat");
    loc = 1'b0; rem = 1'b0;
    step(); #1 push("R10 stays normal");
    stim("R10 normal routing", 1, 2'b10, 0, 2'b01, 1, 2'b11);

    step(); step();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule